// File: doc/BRIEF.md
# Registered Arithmetic Logic Unit with Shifter and Boolean Unit

This block combines three function groups on two W-bit operands: an adder/subtractor, a bitwise Boolean unit and a bidirectional barrel shifter. A 2-bit group select decides which group's output becomes the result. Alongside the result the block produces four condition flags: zero, negative, carry and overflow. Software-visible comparisons can be built by subtracting and reading the flags.

Every output is registered. Inputs presented before a rising clock edge appear on the outputs after that edge, so the latency is one cycle. A synchronous active-high reset clears all outputs. The shifter takes its distance from the low log2(W) bits of operand B and is built as a cascade of stages. Each stage either moves its input by one power of two or passes it through unchanged.

Top module: `alu_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and all four flags become 0 after that edge. Otherwise the outputs reflect the inputs sampled at the previous rising edge.
- R2: With `grp_sel` = 2'b00 and `sub_en` = 0, `result` = (A + B) mod 2^W and `flag_c` is the carry out of bit W-1.
- R3: With `grp_sel` = 2'b00 and `sub_en` = 1, `result` = (A + ~B + 1) mod 2^W and `flag_c` is the carry out of that sum, so `flag_c` = 1 exactly when A >= B as unsigned numbers.
- R4: With `grp_sel` = 2'b00, `flag_v` is 1 exactly when the signed two's-complement result of the add or subtract does not fit in W bits.
- R5: `flag_n` equals bit W-1 of the add/subtract output for the sampled operands, whichever group is selected.
- R6: With `grp_sel` = 2'b01, each result bit comes from the same bit of A and B alone. `bool_fn` selects the function: 00 gives AND, 01 gives OR, 10 gives XOR and 11 gives NOR.
- R7: With `grp_sel` = 2'b11, the result is the same as the Boolean-unit output for 2'b01.
- R8: With `grp_sel` = 2'b10 and `shift_right` = 0, the result is A shifted toward the MSB by B[log2(W)-1:0] places, with the low bits filled with zero. The higher bits of B and `shift_arith` have no effect.
- R9: With `grp_sel` = 2'b10, `shift_right` = 1 and `shift_arith` = 0, the result is A shifted toward the LSB with the vacated high bits filled with zero.
- R10: With `grp_sel` = 2'b10, `shift_right` = 1 and `shift_arith` = 1, the vacated high bits are copies of A[W-1]. For example, 8'hEC shifted by one gives 8'hF6.
- R11: A shift distance of zero returns A unchanged for all three shift types.
- R12: `flag_z` is 1 exactly when the selected final result is zero.
- R13: When `grp_sel` is not 2'b00, `flag_c` and `flag_v` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | Operand A |
| op_b | input | W | Operand B; its low log2(W) bits are the shift distance |
| grp_sel | input | 2 | Function group: 00 arithmetic, 01 Boolean, 10 shift, 11 Boolean copy |
| sub_en | input | 1 | 1 selects subtraction in the arithmetic group |
| bool_fn | input | 2 | Boolean function code |
| shift_right | input | 1 | 1 shifts toward the LSB |
| shift_arith | input | 1 | 1 selects sign fill for right shifts |
| result | output | W | Registered result |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The assertions assume that every control and operand input holds a known value at each rising edge outside reset. They also assume the inputs stay steady between edges, so a property relating one cycle's inputs to the next cycle's outputs refers to a single operation. The stimulus is applied only at falling edges and never leaves an input undriven. Directed vectors cover the carry, overflow and sign-fill corners. A long random run over all groups, codes and shift distances follows, including negative operands under arithmetic right shift and operand-B values with nonzero high bits.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    GRP_ARITH     = 2'b00,
    GRP_LOGIC     = 2'b01,
    GRP_SHIFT     = 2'b10,
    GRP_LOGIC_ALT = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    BF_AND = 2'b00,
    BF_OR  = 2'b01,
    BF_XOR = 2'b10,
    BF_NOR = 2'b11
  } bool_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         v_out
);
  logic [W:0]   carry;
  logic [W-1:0] b_eff;

  assign carry[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign b_eff[i]   = b[i] ^ sub;
    assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
  end

  assign c_out = carry[W];
  assign v_out = carry[W] ^ carry[W-1];

  // Signed overflow only when both addends share a sign that the sum lacks (R4)
  always_comb begin
    if (!$isunknown({a, b, sub}) && v_out) begin
      assert_overflow_signs_R4: assert ((a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]))
        else $error("overflow without sign disagreement");
    end
  end
endmodule

// File: rtl/alu_boolean.sv
module alu_boolean #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] q
);
  import alu_pkg::*;

  // Same cell at each position, no connection between bits (R6)
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (bool_fn_e'(fn))
        BF_AND:  q[i] = a[i] & b[i];
        BF_OR:   q[i] = a[i] | b[i];
        BF_XOR:  q[i] = a[i] ^ b[i];
        default: q[i] = ~(a[i] | b[i]);
      endcase
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0]         a,
  input  logic [$clog2(W)-1:0] amt,
  input  logic                 right,
  input  logic                 arith,
  output logic [W-1:0]         q
);
  localparam int SW = $clog2(W);

  logic [W-1:0] stage [SW+1];
  logic         fill;

  assign fill     = right & arith & a[W-1];
  assign stage[0] = a;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      for (int i = 0; i < W; i++) begin
        if (right) moved[i] = (i + S < W) ? stage[k][i+S] : fill;
        else       moved[i] = (i >= S)    ? stage[k][i-S] : 1'b0;
      end
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign q = stage[SW];

  // A zero distance leaves the operand untouched (R11)
  always_comb begin
    if (!$isunknown({a, amt}) && amt == '0) begin
      assert_zero_amount_passthru_R11: assert (q == a)
        else $error("zero shift altered operand");
    end
  end
endmodule

// File: rtl/alu_unit.sv
module alu_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   grp_sel,
  input  logic         sub_en,
  input  logic [1:0]   bool_fn,
  input  logic         shift_right,
  input  logic         shift_arith,
  output logic [W-1:0] result,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_c,
  output logic         flag_v
);
  import alu_pkg::*;
  localparam int SW = $clog2(W);

  logic [W-1:0] as_sum, bool_q, shf_q, mux_q;
  logic         as_c, as_v, is_arith;

  alu_addsub #(.W(W)) addsub_i (
    .a(op_a), .b(op_b), .sub(sub_en),
    .sum(as_sum), .c_out(as_c), .v_out(as_v)
  );

  alu_boolean #(.W(W)) bool_i (
    .a(op_a), .b(op_b), .fn(bool_fn), .q(bool_q)
  );

  alu_shifter #(.W(W)) shift_i (
    .a(op_a), .amt(op_b[SW-1:0]), .right(shift_right),
    .arith(shift_arith), .q(shf_q)
  );

  assign is_arith = (grp_e'(grp_sel) == GRP_ARITH);

  always_comb begin
    unique case (grp_e'(grp_sel))
      GRP_ARITH: mux_q = as_sum;
      GRP_SHIFT: mux_q = shf_q;
      default:   mux_q = bool_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else begin
      result <= mux_q;
      flag_z <= (mux_q == '0);
      flag_n <= as_sum[W-1];
      flag_c <= is_arith & as_c;
      flag_v <= is_arith & as_v;
    end
  end

  assert_cv_clear_R13: assert property (@(posedge clk) disable iff (rst)
    (grp_sel != 2'b00) |=> (!flag_c && !flag_v));

  assert_zero_flag_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_z == (result == '0)));

  assert_sign_fill_R10: assert property (@(posedge clk) disable iff (rst)
    (grp_sel == 2'b10 && shift_right && shift_arith) |=> (result[W-1] == $past(op_a[W-1])));

  assert_left_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (grp_sel == 2'b10 && !shift_right && op_b[0]) |=> (result[0] == 1'b0));
endmodule

// File: tb/alu_unit_tb.sv
module alu_unit_tb_top;
  localparam int W  = 8;
  localparam int SW = $clog2(W);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [1:0]   grp_sel = '0, bool_fn = '0;
  logic         sub_en = 1'b0, shift_right = 1'b0, shift_arith = 1'b0;
  logic [W-1:0] result;
  logic         flag_z, flag_n, flag_c, flag_v;

  int checks = 0, failures = 0;

  logic         pend = 1'b0;
  logic [W-1:0] e_res;
  logic         e_z, e_n, e_c, e_v;
  string        t_res, t_c, t_v;

  always #5 clk = ~clk;

  alu_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .grp_sel(grp_sel),
    .sub_en(sub_en), .bool_fn(bool_fn), .shift_right(shift_right),
    .shift_arith(shift_arith), .result(result), .flag_z(flag_z),
    .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_pending();
    if (pend) begin
      chk(t_res, "result", result, e_res);
      chk("R12", "flag_z", flag_z, e_z);
      chk("R5", "flag_n", flag_n, e_n);
      chk(t_c, "flag_c", flag_c, e_c);
      chk(t_v, "flag_v", flag_v, e_v);
    end
  endtask

  task automatic op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] g,
                    input logic s, input logic [1:0] f, input logic r, input logic ar);
    int ia, ib, sa, sb, ssum, usum, amt;
    @(negedge clk);
    compare_pending();
    op_a = a; op_b = b; grp_sel = g; sub_en = s; bool_fn = f;
    shift_right = r; shift_arith = ar;
    ia = int'(a); ib = int'(b);
    sa = (ia >= (1 << (W-1))) ? ia - (1 << W) : ia;
    sb = (ib >= (1 << (W-1))) ? ib - (1 << W) : ib;
    usum = s ? ia + ((1 << W) - 1 - ib) + 1 : ia + ib;
    ssum = s ? sa - sb : sa + sb;
    amt  = ib % W;
    e_n = usum[W-1];
    case (g)
      2'b00: begin
        e_res = usum[W-1:0];
        t_res = s ? "R3" : "R2";
        e_c = usum[W]; t_c = s ? "R3" : "R2";
        e_v = (ssum > (1 << (W-1)) - 1) || (ssum < -(1 << (W-1))); t_v = "R4";
      end
      2'b10: begin
        if (!r)      e_res = W'(a << amt);
        else if (ar) e_res = W'($signed(a) >>> amt);
        else         e_res = W'(a >> amt);
        t_res = (amt == 0) ? "R11" : (!r ? "R8" : (ar ? "R10" : "R9"));
        e_c = 1'b0; e_v = 1'b0; t_c = "R13"; t_v = "R13";
      end
      default: begin
        case (f)
          2'b00: e_res = a & b;
          2'b01: e_res = a | b;
          2'b10: e_res = a ^ b;
          default: e_res = ~(a | b);
        endcase
        t_res = (g == 2'b11) ? "R7" : "R6";
        e_c = 1'b0; e_v = 1'b0; t_c = "R13"; t_v = "R13";
      end
    endcase
    e_z = (e_res == '0);
    pend = 1'b1;
  endtask

  initial begin
    #1000000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    op_a = 8'hFF; op_b = 8'h01; grp_sel = 2'b00;
    repeat (3) @(negedge clk);
    // R1: reset clears every output even with live operands
    chk("R1", "result", result, 0);
    chk("R1", "flags", {flag_z, flag_n, flag_c, flag_v}, 0);
    rst = 1'b0;

    op(8'h0D, 8'h05, 2'b00, 0, 0, 0, 0);   // R2 plain add
    op(8'hFF, 8'h01, 2'b00, 0, 0, 0, 0);   // R2 carry out, R12 zero
    op(8'h7F, 8'h01, 2'b00, 0, 0, 0, 0);   // R4 positive overflow
    op(8'h80, 8'h01, 2'b00, 1, 0, 0, 0);   // R4 negative overflow, R3
    op(8'h05, 8'h05, 2'b00, 1, 0, 0, 0);   // R3 equal -> carry, zero
    op(8'h03, 8'h07, 2'b00, 1, 0, 0, 0);   // R3 borrow, R5 negative
    op(8'hAE, 8'h0F, 2'b01, 0, 0, 0, 0);   // R6 AND
    op(8'hAE, 8'h0F, 2'b01, 0, 1, 0, 0);   // R6 OR
    op(8'hAE, 8'h0F, 2'b01, 0, 2, 0, 0);   // R6 XOR
    op(8'hAE, 8'h0F, 2'b11, 0, 3, 0, 0);   // R7 NOR via copy group
    op(8'hFF, 8'hFF, 2'b11, 1, 0, 0, 0);   // R13 no carry outside arith
    op(8'h14, 8'hF9, 2'b10, 0, 0, 0, 1);   // R8 left by 1, high B bits ignored
    op(8'hEC, 8'h01, 2'b10, 0, 0, 1, 1);   // R10 sign fill
    op(8'hEC, 8'h01, 2'b10, 0, 0, 1, 0);   // R9 zero fill
    op(8'h80, 8'h07, 2'b10, 0, 0, 1, 1);   // R10 full-width fill
    op(8'h96, 8'h08, 2'b10, 0, 0, 1, 1);   // R11 zero distance
    op(8'h96, 8'h00, 2'b10, 0, 0, 0, 0);   // R11 left
    op(8'h96, 8'h10, 2'b10, 0, 0, 1, 0);   // R11 logical right

    for (int i = 0; i < 3000; i++) begin
      op(W'($urandom), W'($urandom), 2'($urandom), 1'($urandom),
         2'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    compare_pending();
    pend = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule